// File: doc/BRIEF.md
# DMA Queue Control Register File

This block holds the software-visible control state for every queue of a multi-queue memory-to-memory DMA engine. A 32-bit register bus reaches one window per queue. The windows are spaced 0x100 bytes apart. Each window carries the following fields, all of which the block exports directly to the queue engine:

- the submission and completion ring bases and depths,
- the submission tail doorbell and the completion head pointer,
- the enable and pause bits,
- a one-cycle queue reset pulse.

The engine reports back to the block in three ways. It drives a 4-bit state code, which software can read. It pulses a completion event, which sets an interrupt status bit. It pulses one of three error kinds, each of which sets a status bit and advances its own saturating counter.

Each queue drives one interrupt line. The line is the OR of the pending status bits that the mask leaves open. Software acknowledges a source by writing a one to its status bit. Writing 1 to the reset bit makes the queue return its ring pointers to zero and its state field to idle, without touching the other settings.

Top module: `dmaq_regfile`

## Requirements
- R1: Queue q's window starts at byte address q*0x100. Within a window the field offsets are:
  - submission base low 0x00, submission base high 0x04, submission depth 0x08 (low DEPTH_W bits kept, entries minus one), submission tail 0x0C (low PTR_W bits kept);
  - completion base low 0x10, completion base high 0x14, completion depth 0x18, completion head 0x1C.

  Each field reads back what was written, zero-extended. Read data appears on `bus_rdata` in the cycle after the one in which `bus_rd_en` is sampled.
- R2: An access is ignored, and reads as zero, in each of these cases: the offset is undefined, the address is not word-aligned, or the queue index is NUM_Q or above. Such a write changes no queue state.
- R3: Control word 0 is at offset 0x20. Bit 0 drives `q_enable` and bit 4 drives `q_pause`, both from the cycle after the write. All other bits read as zero.
- R4: Writing 1 to bit 0 of control word 1 (offset 0x24) raises `q_reset` for exactly one cycle. The bit reads as zero once the pulse is over.
- R5: During the reset pulse, the queue's tail and head become zero and its state field becomes idle. Bases, depths, control word 0, mask and counters keep their values.
- R6: Offset 0x30 bits 3:0 return the engine state code registered one cycle earlier. Code 0 means idle and code 1 means run. The field reads 0 after reset.
- R7: Interrupt status is at offset 0x40. Bit 0 is set by a completion event, and bits 1, 2 and 3 are set by error kinds 0, 1 and 2. Writing a one to a bit clears it. If a clear and a new event for the same bit arrive in the same cycle, the bit is set.
- R8: The interrupt mask is at offset 0x44 and resets to 0xF. A mask bit of 1 suppresses its source. `q_irq` is high whenever a status bit is set and its mask bit is 0.
- R9: The error counters are at offset 0x84 for kind 0, 0x88 for kind 1 and 0x8C for kind 2. Each counts events of its kind and saturates at all ones. Writing 0 clears the counter, even if an event arrives in the same cycle. A nonzero write is ignored.
- R10: After reset, every register reads 0 except the mask, which reads 0xF. `q_enable`, `q_pause`, `q_reset` and `q_irq` are all low.
- R11: Each queue's registers, events and outputs are independent of every other queue's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_state | input | NUM_Q*4 | Engine state code per queue |
| cmpl_evt | input | NUM_Q | Completion event pulse per queue |
| err_evt | input | NUM_Q*3 | Error event pulses, three kinds per queue |
| q_enable | output | NUM_Q | Queue enable |
| q_pause | output | NUM_Q | Queue pause |
| q_reset | output | NUM_Q | One-cycle queue reset pulse |
| q_sq_base | output | NUM_Q*64 | Submission ring base |
| q_cq_base | output | NUM_Q*64 | Completion ring base |
| q_sq_depth | output | NUM_Q*DEPTH_W | Submission depth (entries minus one) |
| q_cq_depth | output | NUM_Q*DEPTH_W | Completion depth (entries minus one) |
| q_sq_tail | output | NUM_Q*PTR_W | Submission tail doorbell |
| q_cq_head | output | NUM_Q*PTR_W | Completion head pointer |
| q_irq | output | NUM_Q | Queue interrupt |

## Verification
Every register write takes effect on the clock edge at which it is sampled. The bench drives inputs on falling edges, so it looks at the direct outputs (`q_enable`, `q_pause`, `q_sq_tail`, `q_irq`) at the next falling edge. A read sampled at one rising edge places its data on `bus_rdata` by the following falling edge, and the bench takes it there, before the next edge returns the bus to zero.

The reset pulse is checked twice. It is high at the first falling edge after the write, and at the falling edge one cycle later it has cleared, with the pointers already at zero. Event pulses are held for whole cycles, so a counter value read back equals the number of cycles the event was held, limited by saturation.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

    localparam int DW      = 32;
    localparam int STATE_W = 4;
    localparam int NERR    = 3;
    localparam int INT_W   = 1 + NERR;
    localparam int WIN_LSB = 8;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_PAUSE_BIT = 4;
    localparam int CTRL_RST_BIT   = 0;
    localparam int INT_CMPL_BIT   = 0;
    localparam int INT_ERR_LSB    = 1;

    localparam logic [STATE_W-1:0] ENG_IDLE = 4'h0;
    localparam logic [STATE_W-1:0] ENG_RUN  = 4'h1;

    typedef enum logic [4:0] {
        FLD_NONE,
        FLD_SQB_LO, FLD_SQB_HI, FLD_SQ_DEP, FLD_SQ_TAIL,
        FLD_CQB_LO, FLD_CQB_HI, FLD_CQ_DEP, FLD_CQ_HEAD,
        FLD_CTRL0, FLD_CTRL1, FLD_STATE,
        FLD_ISTS, FLD_IMSK,
        FLD_ERR0, FLD_ERR1, FLD_ERR2
    } fld_e;

    typedef struct packed {
        logic          we;
        fld_e          fld;
        logic [DW-1:0] wdata;
    } wr_req_t;

    function automatic fld_e fld_of(input logic [WIN_LSB-1:0] off);
        fld_e f;
        case (off)
            8'h00:   f = FLD_SQB_LO;
            8'h04:   f = FLD_SQB_HI;
            8'h08:   f = FLD_SQ_DEP;
            8'h0C:   f = FLD_SQ_TAIL;
            8'h10:   f = FLD_CQB_LO;
            8'h14:   f = FLD_CQB_HI;
            8'h18:   f = FLD_CQ_DEP;
            8'h1C:   f = FLD_CQ_HEAD;
            8'h20:   f = FLD_CTRL0;
            8'h24:   f = FLD_CTRL1;
            8'h30:   f = FLD_STATE;
            8'h40:   f = FLD_ISTS;
            8'h44:   f = FLD_IMSK;
            8'h84:   f = FLD_ERR0;
            8'h88:   f = FLD_ERR1;
            8'h8C:   f = FLD_ERR2;
            default: f = FLD_NONE;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/dmaq_addr_dec.sv
module dmaq_addr_dec
    import dmaq_pkg::*;
#(
    parameter int NUM_Q  = 4,
    parameter int ADDR_W = 12,
    localparam int QSEL_W = ADDR_W - WIN_LSB
)(
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [QSEL_W-1:0] qidx,
    output fld_e              fld
);

    fld_e raw_fld;

    always_comb begin
        qidx    = addr[ADDR_W-1:WIN_LSB];
        raw_fld = fld_of(addr[WIN_LSB-1:0]);
        hit     = (raw_fld != FLD_NONE) && (int'(qidx) < NUM_Q);
        fld     = hit ? raw_fld : FLD_NONE;
    end

endmodule

// File: rtl/dmaq_err_cnt.sv
module dmaq_err_cnt #(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (evt && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    assert_saturate_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/dmaq_queue.sv
module dmaq_queue
    import dmaq_pkg::*;
#(
    parameter int DEPTH_W = 16,
    parameter int PTR_W   = 16,
    parameter int CNT_W   = 16
)(
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            wr,
    input  fld_e               rd_fld,
    output logic [DW-1:0]      rd_val,
    input  logic [STATE_W-1:0] eng_state,
    input  logic               cmpl_evt,
    input  logic [NERR-1:0]    err_evt,
    output logic               q_en,
    output logic               q_pause,
    output logic               q_rst,
    output logic [2*DW-1:0]    sq_base,
    output logic [2*DW-1:0]    cq_base,
    output logic [DEPTH_W-1:0] sq_depth,
    output logic [DEPTH_W-1:0] cq_depth,
    output logic [PTR_W-1:0]   sq_tail,
    output logic [PTR_W-1:0]   cq_head,
    output logic               irq
);

    logic [STATE_W-1:0]    st_q;
    logic [INT_W-1:0]      ists_q;
    logic [INT_W-1:0]      imsk_q;
    logic [INT_W-1:0]      ists_set;
    logic [INT_W-1:0]      ists_clr;
    logic [NERR*CNT_W-1:0] cnt_flat;
    logic                  rst_req;

    function automatic logic hit_fld(input wr_req_t w, input fld_e f);
        return w.we && (w.fld == f);
    endfunction

    // configuration words
    always_ff @(posedge clk) begin
        if (rst) begin
            sq_base  <= '0;
            cq_base  <= '0;
            sq_depth <= '0;
            cq_depth <= '0;
            q_en     <= 1'b0;
            q_pause  <= 1'b0;
            imsk_q   <= '1;
        end else begin
            if (hit_fld(wr, FLD_SQB_LO)) sq_base[DW-1:0]    <= wr.wdata;
            if (hit_fld(wr, FLD_SQB_HI)) sq_base[2*DW-1:DW] <= wr.wdata;
            if (hit_fld(wr, FLD_CQB_LO)) cq_base[DW-1:0]    <= wr.wdata;
            if (hit_fld(wr, FLD_CQB_HI)) cq_base[2*DW-1:DW] <= wr.wdata;
            if (hit_fld(wr, FLD_SQ_DEP)) sq_depth <= wr.wdata[DEPTH_W-1:0];
            if (hit_fld(wr, FLD_CQ_DEP)) cq_depth <= wr.wdata[DEPTH_W-1:0];
            if (hit_fld(wr, FLD_CTRL0)) begin
                q_en    <= wr.wdata[CTRL_EN_BIT];
                q_pause <= wr.wdata[CTRL_PAUSE_BIT];
            end
            if (hit_fld(wr, FLD_IMSK)) imsk_q <= wr.wdata[INT_W-1:0];
        end
    end

    // self-clearing reset pulse and the pointers it returns to zero
    assign rst_req = hit_fld(wr, FLD_CTRL1) && wr.wdata[CTRL_RST_BIT];

    always_ff @(posedge clk) begin
        if (rst) q_rst <= 1'b0;
        else     q_rst <= rst_req && !q_rst;
    end

    always_ff @(posedge clk) begin
        if (rst || q_rst) begin
            sq_tail <= '0;
            cq_head <= '0;
        end else begin
            if (hit_fld(wr, FLD_SQ_TAIL)) sq_tail <= wr.wdata[PTR_W-1:0];
            if (hit_fld(wr, FLD_CQ_HEAD)) cq_head <= wr.wdata[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || q_rst) st_q <= ENG_IDLE;
        else              st_q <= eng_state;
    end

    // interrupt status: new events win over a same-cycle acknowledge
    always_comb begin
        ists_set = '0;
        ists_set[INT_CMPL_BIT] = cmpl_evt;
        ists_set[INT_ERR_LSB +: NERR] = err_evt;
        ists_clr = hit_fld(wr, FLD_ISTS) ? wr.wdata[INT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) ists_q <= '0;
        else     ists_q <= (ists_q & ~ists_clr) | ists_set;
    end

    assign irq = |(ists_q & ~imsk_q);

    for (genvar j = 0; j < NERR; j++) begin : g_cnt
        localparam fld_e MY_FLD = (j == 0) ? FLD_ERR0 : (j == 1) ? FLD_ERR1 : FLD_ERR2;
        dmaq_err_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .evt (err_evt[j]),
            .clr (hit_fld(wr, MY_FLD) && (wr.wdata == '0)),
            .cnt (cnt_flat[j*CNT_W +: CNT_W])
        );
    end

    always_comb begin
        rd_val = '0;
        case (rd_fld)
            FLD_SQB_LO:  rd_val = sq_base[DW-1:0];
            FLD_SQB_HI:  rd_val = sq_base[2*DW-1:DW];
            FLD_CQB_LO:  rd_val = cq_base[DW-1:0];
            FLD_CQB_HI:  rd_val = cq_base[2*DW-1:DW];
            FLD_SQ_DEP:  rd_val = DW'(sq_depth);
            FLD_CQ_DEP:  rd_val = DW'(cq_depth);
            FLD_SQ_TAIL: rd_val = DW'(sq_tail);
            FLD_CQ_HEAD: rd_val = DW'(cq_head);
            FLD_CTRL0: begin
                rd_val[CTRL_EN_BIT]    = q_en;
                rd_val[CTRL_PAUSE_BIT] = q_pause;
            end
            FLD_CTRL1:   rd_val[CTRL_RST_BIT] = q_rst;
            FLD_STATE:   rd_val = DW'(st_q);
            FLD_ISTS:    rd_val = DW'(ists_q);
            FLD_IMSK:    rd_val = DW'(imsk_q);
            FLD_ERR0:    rd_val = DW'(cnt_flat[0*CNT_W +: CNT_W]);
            FLD_ERR1:    rd_val = DW'(cnt_flat[1*CNT_W +: CNT_W]);
            FLD_ERR2:    rd_val = DW'(cnt_flat[2*CNT_W +: CNT_W]);
            default:     rd_val = '0;
        endcase
    end

    assert_rst_selfclear_R4: assert property (@(posedge clk) disable iff (rst)
        q_rst |=> !q_rst);

    assert_ptr_zero_R5: assert property (@(posedge clk) disable iff (rst)
        q_rst |=> (sq_tail == '0 && cq_head == '0));

    assert_state_idle_R5: assert property (@(posedge clk) disable iff (rst)
        q_rst |=> (st_q == ENG_IDLE));

    assert_event_sets_R7: assert property (@(posedge clk) disable iff (rst)
        cmpl_evt |=> ists_q[INT_CMPL_BIT]);

    assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
        (hit_fld(wr, FLD_ISTS) && wr.wdata[INT_CMPL_BIT] && !cmpl_evt)
            |=> !ists_q[INT_CMPL_BIT]);

    assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (&imsk_q) |-> !irq);

endmodule

// File: rtl/dmaq_regfile.sv
module dmaq_regfile
    import dmaq_pkg::*;
#(
    parameter int NUM_Q   = 4,
    parameter int ADDR_W  = 12,
    parameter int DEPTH_W = 16,
    parameter int PTR_W   = 16,
    parameter int CNT_W   = 16
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr_en,
    input  logic                       bus_rd_en,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_Q*4-1:0]         eng_state,
    input  logic [NUM_Q-1:0]           cmpl_evt,
    input  logic [NUM_Q*3-1:0]         err_evt,
    output logic [NUM_Q-1:0]           q_enable,
    output logic [NUM_Q-1:0]           q_pause,
    output logic [NUM_Q-1:0]           q_reset,
    output logic [NUM_Q*64-1:0]        q_sq_base,
    output logic [NUM_Q*64-1:0]        q_cq_base,
    output logic [NUM_Q*DEPTH_W-1:0]   q_sq_depth,
    output logic [NUM_Q*DEPTH_W-1:0]   q_cq_depth,
    output logic [NUM_Q*PTR_W-1:0]     q_sq_tail,
    output logic [NUM_Q*PTR_W-1:0]     q_cq_head,
    output logic [NUM_Q-1:0]           q_irq
);

    localparam int QSEL_W = ADDR_W - WIN_LSB;

    logic              dec_hit;
    logic [QSEL_W-1:0] dec_qidx;
    fld_e              dec_fld;
    logic [DW-1:0]     rd_vals [NUM_Q];
    logic [DW-1:0]     rd_sel;

    dmaq_addr_dec #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .qidx (dec_qidx),
        .fld  (dec_fld)
    );

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        wr_req_t wr_i;
        assign wr_i.we    = bus_wr_en && dec_hit && (dec_qidx == QSEL_W'(i));
        assign wr_i.fld   = dec_fld;
        assign wr_i.wdata = bus_wdata;

        dmaq_queue #(.DEPTH_W(DEPTH_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_queue (
            .clk       (clk),
            .rst       (rst),
            .wr        (wr_i),
            .rd_fld    (dec_fld),
            .rd_val    (rd_vals[i]),
            .eng_state (eng_state[i*STATE_W +: STATE_W]),
            .cmpl_evt  (cmpl_evt[i]),
            .err_evt   (err_evt[i*NERR +: NERR]),
            .q_en      (q_enable[i]),
            .q_pause   (q_pause[i]),
            .q_rst     (q_reset[i]),
            .sq_base   (q_sq_base[i*2*DW +: 2*DW]),
            .cq_base   (q_cq_base[i*2*DW +: 2*DW]),
            .sq_depth  (q_sq_depth[i*DEPTH_W +: DEPTH_W]),
            .cq_depth  (q_cq_depth[i*DEPTH_W +: DEPTH_W]),
            .sq_tail   (q_sq_tail[i*PTR_W +: PTR_W]),
            .cq_head   (q_cq_head[i*PTR_W +: PTR_W]),
            .irq       (q_irq[i])
        );
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NUM_Q; i++)
            if (dec_qidx == QSEL_W'(i)) rd_sel = rd_vals[i];
    end

    always_ff @(posedge clk) begin
        if (rst)                       bus_rdata <= '0;
        else if (bus_rd_en && dec_hit) bus_rdata <= rd_sel;
        else                           bus_rdata <= '0;
    end

    assert_miss_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && !dec_hit) |=> (bus_rdata == '0));

    assert_one_reset_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_en |=> (q_reset == '0));

endmodule

// File: tb/dmaq_regfile_bench.sv
module dmaq_regfile_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_Q   = 4;
    localparam int ADDR_W  = 12;
    localparam int DEPTH_W = 16;
    localparam int PTR_W   = 16;
    localparam int CNT_W   = 4;
    localparam int NVEC    = 13;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     bus_wr_en = 1'b0;
    logic                     bus_rd_en = 1'b0;
    logic [ADDR_W-1:0]        bus_addr = '0;
    logic [31:0]              bus_wdata = '0;
    logic [31:0]              bus_rdata;
    logic [NUM_Q*4-1:0]       eng_state = '0;
    logic [NUM_Q-1:0]         cmpl_evt = '0;
    logic [NUM_Q*3-1:0]       err_evt = '0;
    logic [NUM_Q-1:0]         q_enable, q_pause, q_reset, q_irq;
    logic [NUM_Q*64-1:0]      q_sq_base, q_cq_base;
    logic [NUM_Q*DEPTH_W-1:0] q_sq_depth, q_cq_depth;
    logic [NUM_Q*PTR_W-1:0]   q_sq_tail, q_cq_head;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmaq_regfile #(
        .NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W),
        .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) u_dmaq_regfile (
        .clk(clk), .rst(rst),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_state(eng_state), .cmpl_evt(cmpl_evt), .err_evt(err_evt),
        .q_enable(q_enable), .q_pause(q_pause), .q_reset(q_reset),
        .q_sq_base(q_sq_base), .q_cq_base(q_cq_base),
        .q_sq_depth(q_sq_depth), .q_cq_depth(q_cq_depth),
        .q_sq_tail(q_sq_tail), .q_cq_head(q_cq_head), .q_irq(q_irq)
    );

    // {req, addr, wdata, expected readback}
    localparam logic [79:0] VEC [NVEC] = '{
        {4'd1,  12'h000, 32'hDEADBEEF, 32'hDEADBEEF},
        {4'd1,  12'h004, 32'h12345678, 32'h12345678},
        {4'd1,  12'h008, 32'h000003FF, 32'h000003FF},
        {4'd1,  12'h00C, 32'hABCD1234, 32'h00001234},
        {4'd1,  12'h110, 32'hCAFEF00D, 32'hCAFEF00D},
        {4'd1,  12'h114, 32'h00000001, 32'h00000001},
        {4'd1,  12'h118, 32'hFFFF0010, 32'h00000010},
        {4'd1,  12'h21C, 32'h00000055, 32'h00000055},
        {4'd3,  12'h320, 32'hFFFFFFFF, 32'h00000011},
        {4'd8,  12'h044, 32'h00000005, 32'h00000005},
        {4'd2,  12'h050, 32'h12345678, 32'h00000000},
        {4'd2,  12'h400, 32'h77777777, 32'h00000000},
        {4'd2,  12'h006, 32'h99999999, 32'h00000000}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, 64'(d), 64'(exp));
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 100000);
                $display("test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        chk("R10", 64'(q_enable), 64'h0);
        chk("R10", 64'(q_irq), 64'h0);
        chk("R10", 64'(q_reset), 64'h0);
        rdchk("R10", 12'h044, 32'hF);
        rdchk("R10", 12'h10C, 32'h0);
        rdchk("R6", 12'h030, 32'h0);

        // table walk: R1 map and readback, R2 holes, R3 control, R8 mask
        for (int k = 0; k < NVEC; k++) begin
            logic [31:0] d;
            wr(VEC[k][75:64], VEC[k][63:32]);
            rd(VEC[k][75:64], d);
            n_chk++;
            if (d !== VEC[k][31:0]) begin
                n_bad++;
                $display("FAIL R%0d addr=%h: actual=%h expected=%h",
                         VEC[k][79:76], VEC[k][75:64], d, VEC[k][31:0]);
            end
        end

        // R1 outputs, R2 no aliasing into queue 0, R3 outputs
        chk("R1", q_sq_base[63:0], 64'h12345678DEADBEEF);
        chk("R1", 64'(q_sq_depth[15:0]), 64'h3FF);
        chk("R1", 64'(q_cq_depth[1*16 +: 16]), 64'h10);
        rdchk("R2", 12'h000, 32'hDEADBEEF);
        rdchk("R2", 12'h004, 32'h12345678);
        chk("R3", 64'(q_enable), 64'b1000);
        chk("R3", 64'(q_pause), 64'b1000);
        wr(12'h320, 32'h00000001);
        chk("R3", 64'(q_pause), 64'h0);
        chk("R3", 64'(q_enable), 64'b1000);

        // R4 / R5: queue reset on queue 2
        wr(12'h20C, 32'h00000020);
        wr(12'h220, 32'h00000001);
        wr(12'h224, 32'h00000001);
        chk("R4", 64'(q_reset), 64'b0100);
        @(negedge clk);
        chk("R4", 64'(q_reset), 64'h0);
        chk("R5", 64'(q_sq_tail[2*16 +: 16]), 64'h0);
        chk("R5", 64'(q_cq_head[2*16 +: 16]), 64'h0);
        chk("R5", 64'(q_enable[2]), 64'h1);
        rdchk("R4", 12'h224, 32'h0);
        rdchk("R5", 12'h21C, 32'h0);
        chk("R11", 64'(q_sq_tail[0 +: 16]), 64'h1234);

        // R6: engine state readback
        eng_state[1*4 +: 4] = 4'h1;
        @(negedge clk);
        rdchk("R6", 12'h130, 32'h1);
        rdchk("R6", 12'h030, 32'h0);
        eng_state[1*4 +: 4] = 4'h0;

        // R7 / R8: queue 0 mask is 0x5
        cmpl_evt[0] = 1'b1; @(negedge clk); cmpl_evt[0] = 1'b0;
        chk("R8", 64'(q_irq), 64'h0);
        rdchk("R7", 12'h040, 32'h1);
        err_evt[0] = 1'b1; @(negedge clk); err_evt[0] = 1'b0;
        chk("R8", 64'(q_irq), 64'b0001);
        rdchk("R7", 12'h040, 32'h3);
        wr(12'h040, 32'h00000002);
        chk("R7", 64'(q_irq), 64'h0);
        rdchk("R7", 12'h040, 32'h1);
        wr(12'h044, 32'h00000000);
        chk("R8", 64'(q_irq), 64'b0001);
        // acknowledge and new completion in the same cycle: bit stays set
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 12'h040; bus_wdata = 32'h1; cmpl_evt[0] = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; cmpl_evt[0] = 1'b0;
        rdchk("R7", 12'h040, 32'h1);
        wr(12'h040, 32'h00000001);
        chk("R7", 64'(q_irq), 64'h0);
        rdchk("R9", 12'h084, 32'h1);

        // R9: queue 1, error kind 2
        err_evt[1*3 + 2] = 1'b1;
        repeat (3) @(negedge clk);
        err_evt[1*3 + 2] = 1'b0;
        rdchk("R9", 12'h18C, 32'h3);
        wr(12'h18C, 32'h00000005);
        rdchk("R9", 12'h18C, 32'h3);
        err_evt[1*3 + 2] = 1'b1;
        repeat (20) @(negedge clk);
        err_evt[1*3 + 2] = 1'b0;
        rdchk("R9", 12'h18C, 32'hF);
        rdchk("R11", 12'h184, 32'h0);
        chk("R11", 64'(q_irq), 64'h0);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 12'h18C; bus_wdata = 32'h0; err_evt[1*3 + 2] = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; err_evt[1*3 + 2] = 1'b0;
        rdchk("R9", 12'h18C, 32'h0);
        rdchk("R11", 12'h140, 32'h8);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule